// File: doc/BRIEF.md
# Pixel Color Resolver

The block turns one pixel word per valid cycle into three 8-bit channel values for a digital-to-analog output stage. In the two indexed depths (4 and 8 bits per pixel) the pixel is an address into a 256-word color table. The host loads that table through a dedicated write port. In the two direct depths (16 and 24 bits per pixel) the table is skipped and the packed red, green and blue fields are widened to 8 bits each.

A six-bit resolution setting can coarsen the channels. Every result leaves through one register stage, so the output valid flag trails the input valid flag by exactly one cycle on every path. The host can load table words at any time, including while pixels are streaming.

Top module: `palette_color_path`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `outValid` is 0 and all three channels are 0.
- R2: `outValid` equals the value `pixValid` had one clock earlier. Channels for a pixel appear in the cycle after it is accepted.
- R3: Mode 0 (4 bpp): only `pixData[3:0]` forms the table address, so addresses run 0..15. `pixData[23:4]` has no effect. The table word gives red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: Mode 1 (8 bpp): `pixData[7:0]` addresses any of the 256 table words.
- R5: Mode 2 with `fmt565`=1 and `bypassEn`=1: red is bits 15:11, green is bits 10:5 and blue is bits 4:0. A 5-bit field x widens to {x, x[4:2]} and a 6-bit field y widens to {y, y[5:4]}.
- R6: Mode 2 with `fmt565`=0 and `bypassEn`=1: red is bits 14:10, green is bits 9:5 and blue is bits 4:0, each widened as a 5-bit field. Bit 15 and bits 23:16 are ignored.
- R7: Mode 3 with `bypassEn`=1: red is bits 23:16, green is bits 15:8 and blue is bits 7:0, passed unchanged. `dacSixBit` has no effect in this mode.
- R8: With `dacSixBit`=1, in modes 0 to 2 the two low bits of every channel are 0.
- R9: In modes 2 and 3 with `bypassEn`=0, all channels are 0.
- R10: A table write presented on a clock edge is seen by pixels accepted on later edges. A pixel that reads the same address on that same edge gets the old word.
- R11: When `pixValid` is 0, the channel outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel word valid |
| pixData | input | 24 | Unpacked pixel word |
| pixMode | input | 2 | 0=4 bpp, 1=8 bpp, 2=16 bpp, 3=24 bpp |
| fmt565 | input | 1 | 16 bpp layout: 1=5:6:5, 0=5:5:5 |
| dacSixBit | input | 1 | Six-bit channel resolution |
| bypassEn | input | 1 | Direct color enable for modes 2 and 3 |
| palWrEn | input | 1 | Table write strobe |
| palWrAddr | input | 8 | Table write address |
| palWrData | input | 24 | Table write word, red high |
| outValid | output | 1 | Output channels valid |
| outRed | output | 8 | Red channel |
| outGreen | output | 8 | Green channel |
| outBlue | output | 8 | Blue channel |

## Verification
A host table write and an indexed pixel lookup can fall on the same clock edge and hit the same address. The bench provokes this in two ways. Directed steps write an address while a 4-bit or 8-bit pixel reads it, then read it again on the next edge. Random steps also mix writes into the pixel stream. The bench judges every result against a shadow table that it updates only after computing the expected value for that cycle. The same-edge read must return the old word and the next read must return the new one.

// File: rtl/palette_color_pkg.sv
package palette_color_pkg;
  localparam int ChanW = 8;
  localparam int PixW = 3 * ChanW;
  localparam int IdxW = 8;
  localparam int Entries = 1 << IdxW;

  typedef enum logic [1:0] {
    MODE_IDX4  = 2'd0,
    MODE_IDX8  = 2'd1,
    MODE_RGB16 = 2'd2,
    MODE_RGB24 = 2'd3
  } pixMode_e;

  typedef struct packed {
    logic load;
    logic useTable;
    logic narrowIdx;
    logic wideGreen;
    logic fullDirect;
    logic killOut;
    logic trunc6;
  } pathCtrl_t;
endpackage

// File: rtl/palette_color_ctrl.sv
module palette_color_ctrl
  import palette_color_pkg::*;
(
  input  logic      pixValid,
  input  logic [1:0] pixMode,
  input  logic      fmt565,
  input  logic      dacSixBit,
  input  logic      bypassEn,
  output pathCtrl_t ctrl
);
  pixMode_e modeSel;

  always_comb begin
    modeSel = pixMode_e'(pixMode);
    ctrl = '0;
    ctrl.load = pixValid;
    ctrl.useTable = (modeSel == MODE_IDX4) || (modeSel == MODE_IDX8);
    ctrl.narrowIdx = (modeSel == MODE_IDX4);
    ctrl.wideGreen = fmt565;
    ctrl.fullDirect = (modeSel == MODE_RGB24);
    ctrl.killOut = !ctrl.useTable && !bypassEn;
    ctrl.trunc6 = dacSixBit && (modeSel != MODE_RGB24);
  end
endmodule

// File: rtl/palette_color_datapath.sv
module palette_color_datapath
  import palette_color_pkg::*;
#(
  parameter int CW = ChanW,
  parameter int AW = IdxW
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtrl_t         ctrl,
  input  logic [3*CW-1:0]   pixData,
  input  logic              palWrEn,
  input  logic [AW-1:0]     palWrAddr,
  input  logic [3*CW-1:0]   palWrData,
  output logic              outValid,
  output logic [CW-1:0]     outRed,
  output logic [CW-1:0]     outGreen,
  output logic [CW-1:0]     outBlue
);
  localparam int Depth = 1 << AW;
  localparam int WordW = 3 * CW;

  logic [WordW-1:0] table_q [Depth];
  logic [AW-1:0]    rdIdx;
  logic [WordW-1:0] lutWord;
  logic [CW-1:0]    dirR, dirG, dirB;
  logic [CW-1:0]    selR, selG, selB;
  logic [CW-1:0]    chanMask;

  always_ff @(posedge clk) begin
    if (palWrEn) table_q[palWrAddr] <= palWrData;
  end

  always_comb begin
    rdIdx = ctrl.narrowIdx ? {{(AW-4){1'b0}}, pixData[3:0]} : pixData[AW-1:0];
    lutWord = table_q[rdIdx];
  end

  always_comb begin
    if (ctrl.fullDirect) begin
      dirR = pixData[3*CW-1:2*CW];
      dirG = pixData[2*CW-1:CW];
      dirB = pixData[CW-1:0];
    end else if (ctrl.wideGreen) begin
      dirR = {pixData[15:11], pixData[15:13]};
      dirG = {pixData[10:5], pixData[10:9]};
      dirB = {pixData[4:0], pixData[4:2]};
    end else begin
      dirR = {pixData[14:10], pixData[14:12]};
      dirG = {pixData[9:5], pixData[9:7]};
      dirB = {pixData[4:0], pixData[4:2]};
    end
  end

  always_comb begin
    chanMask = ctrl.trunc6 ? {{(CW-2){1'b1}}, 2'b00} : {CW{1'b1}};
    if (ctrl.killOut) begin
      selR = '0;
      selG = '0;
      selB = '0;
    end else if (ctrl.useTable) begin
      selR = lutWord[3*CW-1:2*CW] & chanMask;
      selG = lutWord[2*CW-1:CW] & chanMask;
      selB = lutWord[CW-1:0] & chanMask;
    end else begin
      selR = dirR & chanMask;
      selG = dirG & chanMask;
      selB = dirB & chanMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outRed <= '0;
      outGreen <= '0;
      outBlue <= '0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        outRed <= selR;
        outGreen <= selG;
        outBlue <= selB;
      end
    end
  end
endmodule

// File: rtl/palette_color_path.sv
module palette_color_path
  import palette_color_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pixValid,
  input  logic [23:0] pixData,
  input  logic [1:0]  pixMode,
  input  logic        fmt565,
  input  logic        dacSixBit,
  input  logic        bypassEn,
  input  logic        palWrEn,
  input  logic [7:0]  palWrAddr,
  input  logic [23:0] palWrData,
  output logic        outValid,
  output logic [7:0]  outRed,
  output logic [7:0]  outGreen,
  output logic [7:0]  outBlue
);
  pathCtrl_t ctrl;

  palette_color_ctrl u_ctrl (
    .pixValid(pixValid), .pixMode(pixMode), .fmt565(fmt565),
    .dacSixBit(dacSixBit), .bypassEn(bypassEn), .ctrl(ctrl)
  );

  palette_color_datapath #(.CW(8), .AW(8)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pixData(pixData),
    .palWrEn(palWrEn), .palWrAddr(palWrAddr), .palWrData(palWrData),
    .outValid(outValid), .outRed(outRed), .outGreen(outGreen), .outBlue(outBlue)
  );
endmodule

// File: rtl/palette_color_path_chk.sv
module palette_color_path_chk (
  input logic        clk,
  input logic        rstN,
  input logic        pixValid,
  input logic [23:0] pixData,
  input logic [1:0]  pixMode,
  input logic        dacSixBit,
  input logic        bypassEn,
  input logic        outValid,
  input logic [7:0]  outRed,
  input logic [7:0]  outGreen,
  input logic [7:0]  outBlue
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!outValid && outRed == 8'd0 && outGreen == 8'd0 && outBlue == 8'd0));

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);

  assert_idle_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);

  assert_direct24_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixMode == 2'd3 && bypassEn) |=>
      (outRed == $past(pixData[23:16]) && outGreen == $past(pixData[15:8])
       && outBlue == $past(pixData[7:0])));

  assert_six_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && dacSixBit && pixMode != 2'd3) |=>
      (outRed[1:0] == 2'b00 && outGreen[1:0] == 2'b00 && outBlue[1:0] == 2'b00));

  assert_no_bypass_black_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixMode[1] && !bypassEn) |=>
      (outRed == 8'd0 && outGreen == 8'd0 && outBlue == 8'd0));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!pixValid && $past(rstN)) |=> ($stable(outRed) && $stable(outGreen) && $stable(outBlue)));
endmodule

bind palette_color_path palette_color_path_chk u_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
  .pixMode(pixMode), .dacSixBit(dacSixBit), .bypassEn(bypassEn),
  .outValid(outValid), .outRed(outRed), .outGreen(outGreen), .outBlue(outBlue)
);

// File: tb/palette_color_path_test.sv
module palette_color_path_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixValid = 1'b0;
  logic [23:0] pixData = '0;
  logic [1:0] pixMode = '0;
  logic fmt565 = 1'b0;
  logic dacSixBit = 1'b0;
  logic bypassEn = 1'b0;
  logic palWrEn = 1'b0;
  logic [7:0] palWrAddr = '0;
  logic [23:0] palWrData = '0;
  logic outValid;
  logic [7:0] outRed, outGreen, outBlue;

  logic [23:0] shadow [256];
  logic [23:0] lastRgb = '0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  palette_color_path uut (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .pixMode(pixMode), .fmt565(fmt565), .dacSixBit(dacSixBit),
    .bypassEn(bypassEn), .palWrEn(palWrEn), .palWrAddr(palWrAddr),
    .palWrData(palWrData), .outValid(outValid), .outRed(outRed),
    .outGreen(outGreen), .outBlue(outBlue)
  );

  function automatic logic [23:0] expectRgb(input logic [1:0] m, input logic [23:0] p,
      input logic f565, input logic six, input logic byp);
    logic [7:0] r, g, b;
    logic [23:0] w;
    if (m[1] && !byp) return 24'd0;
    case (m)
      2'd0: w = shadow[{4'd0, p[3:0]}];
      2'd1: w = shadow[p[7:0]];
      2'd2: begin
        if (f565) w = {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
        else      w = {p[14:10], p[14:12], p[9:5], p[9:7], p[4:0], p[4:2]};
      end
      default: w = p;
    endcase
    r = w[23:16]; g = w[15:8]; b = w[7:0];
    if (six && m != 2'd3) begin
      r[1:0] = 2'b00; g[1:0] = 2'b00; b[1:0] = 2'b00;
    end
    return {r, g, b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string reqFor(input logic [1:0] m, input logic f565, input logic byp);
    if (m[1] && !byp) return "R9";
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return f565 ? "R5" : "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input logic v, input logic [1:0] m, input logic [23:0] p,
      input logic f565, input logic six, input logic byp,
      input logic we, input logic [7:0] wa, input logic [23:0] wd, input string tag);
    logic [23:0] exp;
    @(negedge clk);
    pixValid = v; pixMode = m; pixData = p; fmt565 = f565;
    dacSixBit = six; bypassEn = byp;
    palWrEn = we; palWrAddr = wa; palWrData = wd;
    exp = v ? expectRgb(m, p, f565, six, byp) : lastRgb;
    @(posedge clk);
    #1;
    if (we) shadow[wa] = wd;
    check("R2", {31'd0, outValid}, {31'd0, v});
    check(v ? tag : "R11", {8'd0, outRed, outGreen, outBlue}, {8'd0, exp});
    lastRgb = exp;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", {7'd0, outValid, outRed, outGreen, outBlue}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1", {7'd0, outValid, outRed, outGreen, outBlue}, 32'd0);

    for (int i = 0; i < 256; i++)
      step(1'b0, 2'd0, 24'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'(i), $urandom() & 24'hFFFFFF, "R11");

    step(1'b1, 2'd0, 24'hABCDE5, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 24'd0, "R3");
    step(1'b1, 2'd1, 24'h0000F5, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 24'd0, "R4");
    step(1'b1, 2'd2, 24'h00F81F, 1'b1, 1'b0, 1'b1, 1'b0, 8'd0, 24'd0, "R5");
    step(1'b1, 2'd2, 24'hFF8000, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 24'd0, "R6");
    step(1'b1, 2'd3, 24'h123457, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 24'd0, "R7");
    step(1'b1, 2'd2, 24'h00FFFF, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 24'd0, "R8");
    step(1'b1, 2'd3, 24'hFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 24'd0, "R9");
    step(1'b0, 2'd1, 24'h000033, 1'b0, 1'b0, 1'b0, 1'b1, 8'h33, 24'h0A0B0C, "R11");
    step(1'b1, 2'd1, 24'h000042, 1'b0, 1'b0, 1'b0, 1'b1, 8'h42, 24'h5A6B7C, "R10");
    step(1'b1, 2'd1, 24'h000042, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 24'd0, "R10");
    step(1'b1, 2'd0, 24'hFFFF37, 1'b0, 1'b1, 1'b0, 1'b1, 8'h07, 24'hFFFFFF, "R10");
    step(1'b1, 2'd0, 24'h000007, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 24'd0, "R10");

    for (int i = 0; i < 400; i++) begin
      logic [1:0] m;
      logic byp, f565, v, we;
      logic [7:0] wa;
      m = 2'($urandom_range(0, 3));
      byp = ($urandom_range(0, 7) != 0);
      f565 = 1'($urandom());
      v = ($urandom_range(0, 5) != 0);
      we = ($urandom_range(0, 3) == 0);
      wa = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 15)) : 8'($urandom());
      step(v, m, $urandom() & 24'hFFFFFF, f565, 1'($urandom()), byp,
           we, wa, $urandom() & 24'hFFFFFF, reqFor(m, f565, byp));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule